// File: doc/BRIEF.md
# Bias branch cache filter

A set-associative cache of conditional branches placed in front of a neural branch predictor. Every entry carries a partial tag, a private 7-bit signed bias weight and two sticky direction flags: one records that the branch has been seen taken, the other that it has been seen not taken. Because each cached branch owns its bias, bias weights never alias between branches.

A lookup made at prediction time returns hit or miss, the entry's bias and, for a branch that has shown only one direction so far, a filtered prediction in that direction. A lookup that misses claims the least-recently-used way of the set at the next clock edge. A commit port updates the flags and the bias of a resident branch, and tells the neural trainer to skip training while the branch remains one-directional. Commits for branches that are no longer resident are dropped.

Top module: `bias_filter_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `lk_hit`=0 and `lk_filt_valid`=0.
- R2: The set is `pc[IDX_W-1:0]` (IDX_W = log2 SETS) and the tag is the next TAG_W bits `pc[IDX_W+TAG_W-1:IDX_W]`. A lookup hits only on a valid entry of that set whose tag matches, so a different tag in the same set misses.
- R3: A lookup that misses allocates an entry at the following clock edge. A later lookup of the same PC hits with bias 0 and no filtered prediction, because both flags start clear.
- R4: A commit that hits sets the taken flag when `cm_taken`=1 and the not-taken flag when `cm_taken`=0. Flags are never cleared while the entry stays resident.
- R5: `lk_filt_valid`=1 exactly when the lookup hits and exactly one flag is set. `lk_filt_dir` is 1 when only the taken flag is set and 0 when only the not-taken flag is set.
- R6: A lookup hit or an allocation makes that way most-recently-used. An allocation replaces the least-recently-used way of the set, so invalid ways fill before any valid entry is evicted.
- R7: `cm_suppress`=1 exactly when the commit hits and the flags after this commit show exactly one direction.
- R8: A hitting commit with `cm_train`=1 and `cm_suppress`=0 steps the bias by +1 when taken and by -1 when not taken, saturating at +63 and -64 (two's complement). With `cm_train`=0, or with `cm_suppress`=1, the bias is left unchanged.
- R9: A commit that misses reports `cm_hit`=0 and `cm_suppress`=0, changes no state and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request at prediction time |
| lk_pc | input | PC_W | Lookup branch address |
| lk_hit | output | 1 | Lookup found a resident entry |
| lk_bias | output | BIAS_W | Bias weight of the hit entry, two's complement |
| lk_filt_valid | output | 1 | Branch has shown one direction only; use `lk_filt_dir` |
| lk_filt_dir | output | 1 | Filtered prediction, 1 = taken |
| cm_valid | input | 1 | Commit of a resolved branch |
| cm_pc | input | PC_W | Commit branch address |
| cm_taken | input | 1 | Resolved outcome, 1 = taken |
| cm_train | input | 1 | Neural trainer requests a training round |
| cm_hit | output | 1 | Commit found a resident entry |
| cm_suppress | output | 1 | Skip neural training for this commit |

## Verification
The assertions assume that a lookup which misses is not followed by a commit of the same branch in the same cycle as the allocation. They also assume that the PC held on the lookup port in the next cycle belongs to the same branch whenever it is compared with the previous one. The directed tasks drive one port at a time, lookups first and commits afterwards, so allocation and commit never overlap. Each task uses its own sets so that earlier scenarios cannot disturb the expected LRU order.

// File: rtl/bias_filter_cache.sv
module bias_filter_cache #(
  parameter int PC_W   = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int BIAS_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_hit,
  output logic [BIAS_W-1:0] lk_bias,
  output logic              lk_filt_valid,
  output logic              lk_filt_dir,
  input  logic              cm_valid,
  input  logic [PC_W-1:0]   cm_pc,
  input  logic              cm_taken,
  input  logic              cm_train,
  output logic              cm_hit,
  output logic              cm_suppress
);
  localparam int IDX_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS-1);
  localparam logic [BIAS_W-1:0] BMAX = {1'b0, {(BIAS_W-1){1'b1}}};
  localparam logic [BIAS_W-1:0] BMIN = {1'b1, {(BIAS_W-1){1'b0}}};

  logic              val_q  [SETS][WAYS];
  logic              et_q   [SETS][WAYS];
  logic              en_q   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [BIAS_W-1:0] bias_q [SETS][WAYS];
  logic [AGE_W-1:0]  age_q  [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, cm_set;
  logic [TAG_W-1:0] lk_tag, cm_tag;
  logic [AGE_W-1:0] lk_way, cm_way, victim, touch;

  assign lk_set = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[IDX_W +: TAG_W];
  assign cm_set = cm_pc[IDX_W-1:0];
  assign cm_tag = cm_pc[IDX_W +: TAG_W];

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (val_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_hit = 1'b1;
        lk_way = AGE_W'(w);
      end
      if (age_q[lk_set][w] == OLDEST) victim = AGE_W'(w);
    end
  end

  always_comb begin
    cm_hit = 1'b0;
    cm_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (val_q[cm_set][w] && tag_q[cm_set][w] == cm_tag) begin
        cm_hit = 1'b1;
        cm_way = AGE_W'(w);
      end
  end

  assign touch = lk_hit ? lk_way : victim;

  logic lk_et, lk_en;
  assign lk_et         = et_q[lk_set][lk_way];
  assign lk_en         = en_q[lk_set][lk_way];
  assign lk_bias       = lk_hit ? bias_q[lk_set][lk_way] : '0;
  assign lk_filt_valid = lk_hit && (lk_et ^ lk_en);
  assign lk_filt_dir   = lk_filt_valid && lk_et;

  logic              nx_et, nx_en, single;
  logic [BIAS_W-1:0] cur_b, nx_b;
  assign nx_et       = et_q[cm_set][cm_way] | cm_taken;
  assign nx_en       = en_q[cm_set][cm_way] | ~cm_taken;
  assign single      = nx_et ^ nx_en;
  assign cm_suppress = cm_valid && cm_hit && single;
  assign cur_b       = bias_q[cm_set][cm_way];

  always_comb begin
    nx_b = cur_b;
    if (cm_train && !single) begin
      if (cm_taken && cur_b != BMAX) nx_b = cur_b + 1'b1;
      else if (!cm_taken && cur_b != BMIN) nx_b = cur_b - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          val_q[s][w]  <= 1'b0;
          et_q[s][w]   <= 1'b0;
          en_q[s][w]   <= 1'b0;
          tag_q[s][w]  <= '0;
          bias_q[s][w] <= '0;
          age_q[s][w]  <= AGE_W'(w);
        end
    end else begin
      if (cm_valid && cm_hit) begin
        et_q[cm_set][cm_way]   <= nx_et;
        en_q[cm_set][cm_way]   <= nx_en;
        bias_q[cm_set][cm_way] <= nx_b;
      end
      if (lk_valid) begin
        if (!lk_hit) begin
          val_q[lk_set][victim]  <= 1'b1;
          tag_q[lk_set][victim]  <= lk_tag;
          bias_q[lk_set][victim] <= '0;
          et_q[lk_set][victim]   <= 1'b0;
          en_q[lk_set][victim]   <= 1'b0;
        end
        for (int w = 0; w < WAYS; w++) begin
          if (AGE_W'(w) == touch) age_q[lk_set][w] <= '0;
          else if (age_q[lk_set][w] < age_q[lk_set][touch])
            age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bias_filter_cache_chk.sv
module bias_filter_cache_chk #(
  parameter int PC_W   = 32,
  parameter int BIAS_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_hit,
  input logic [BIAS_W-1:0] lk_bias,
  input logic              lk_filt_valid,
  input logic              lk_filt_dir,
  input logic              cm_valid,
  input logic              cm_hit,
  input logic              cm_suppress
);
  AST_FILT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_filt_valid |-> lk_hit); // R5
  AST_DIR_NEEDS_FILT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_filt_dir |-> lk_filt_valid); // R5
  AST_SUPPRESS_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cm_suppress |-> (cm_valid && cm_hit)); // R7
  AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) ##1 (lk_valid && lk_pc == $past(lk_pc))
      |-> (lk_hit && lk_bias == '0 && !lk_filt_valid)); // R3
  AST_MRU_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit) ##1 (lk_valid && lk_pc == $past(lk_pc)) |-> lk_hit); // R6
endmodule

bind bias_filter_cache bias_filter_cache_chk #(.PC_W(PC_W), .BIAS_W(BIAS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit),
  .lk_bias(lk_bias), .lk_filt_valid(lk_filt_valid), .lk_filt_dir(lk_filt_dir),
  .cm_valid(cm_valid), .cm_hit(cm_hit), .cm_suppress(cm_suppress));

// File: tb/bias_filter_cache_bench.sv
module bias_filter_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, cm_valid = 1'b0, cm_taken = 1'b0, cm_train = 1'b0;
  logic [31:0] lk_pc = '0, cm_pc = '0;
  logic lk_hit, lk_filt_valid, lk_filt_dir, cm_hit, cm_suppress;
  logic [6:0] lk_bias;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bias_filter_cache u_bias_filter_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_hit(lk_hit),
    .lk_bias(lk_bias), .lk_filt_valid(lk_filt_valid), .lk_filt_dir(lk_filt_dir),
    .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_taken(cm_taken), .cm_train(cm_train),
    .cm_hit(cm_hit), .cm_suppress(cm_suppress));

  function automatic logic [31:0] mkpc(int s, int t);
    return {16'h0, 10'(t), 6'(s)};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic r_hit, r_fv, r_fd, r_chit, r_sup;
  logic signed [6:0] r_bias;

  task automatic look(logic [31:0] pc);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    #1;
    r_hit = lk_hit; r_bias = lk_bias; r_fv = lk_filt_valid; r_fd = lk_filt_dir;
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic commit(logic [31:0] pc, logic tk, logic tr);
    @(negedge clk);
    cm_valid = 1'b1; cm_pc = pc; cm_taken = tk; cm_train = tr;
    #1;
    r_chit = cm_hit; r_sup = cm_suppress;
    @(posedge clk); #1;
    cm_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(mkpc(3, 11));
    chk("R1", "hit after reset", r_hit, 0);
    chk("R1", "filt after reset", r_fv, 0);
  endtask

  task automatic t_alloc;
    look(mkpc(7, 20));
    chk("R3", "first lookup misses", r_hit, 0);
    look(mkpc(7, 20));
    chk("R3", "second lookup hits", r_hit, 1);
    chk("R3", "fresh bias", int'(r_bias), 0);
    chk("R3", "fresh filt", r_fv, 0);
    look(mkpc(7, 21));
    chk("R2", "other tag same set misses", r_hit, 0);
    look(mkpc(8, 20));
    chk("R2", "same tag other set misses", r_hit, 0);
  endtask

  task automatic t_flags_bias;
    logic [31:0] a = mkpc(1, 1);
    logic [31:0] b = mkpc(2, 1);
    look(a);
    commit(a, 1'b1, 1'b1);
    chk("R7", "first outcome suppress", r_sup, 1);
    look(a);
    chk("R5", "taken-only filt", r_fv, 1);
    chk("R5", "taken-only dir", r_fd, 1);
    chk("R8", "bias kept while suppressed", int'(r_bias), 0);
    commit(a, 1'b1, 1'b1);
    chk("R7", "repeat outcome suppress", r_sup, 1);
    commit(a, 1'b0, 1'b1);
    chk("R7", "mixed outcome no suppress", r_sup, 0);
    look(a);
    chk("R4", "both flags -> no filt", r_fv, 0);
    chk("R8", "bias -1", int'(r_bias), -1);
    commit(a, 1'b1, 1'b0);
    look(a);
    chk("R8", "train=0 leaves bias", int'(r_bias), -1);
    chk("R4", "flags sticky", r_fv, 0);
    for (int i = 0; i < 70; i++) commit(a, 1'b1, 1'b1);
    look(a);
    chk("R8", "saturate high", int'(r_bias), 63);
    for (int i = 0; i < 140; i++) commit(a, 1'b0, 1'b1);
    look(a);
    chk("R8", "saturate low", int'(r_bias), -64);
    look(b);
    commit(b, 1'b0, 1'b1);
    look(b);
    chk("R5", "not-taken-only filt", r_fv, 1);
    chk("R5", "not-taken-only dir", r_fd, 0);
  endtask

  task automatic t_lru;
    for (int t = 1; t <= 4; t++) look(mkpc(5, t));
    look(mkpc(5, 1));
    chk("R6", "invalid ways fill first", r_hit, 1);
    look(mkpc(5, 5));
    chk("R6", "fifth tag misses", r_hit, 0);
    commit(mkpc(5, 2), 1'b1, 1'b1);
    chk("R9", "commit to evicted entry hit", r_chit, 0);
    chk("R9", "commit to evicted entry suppress", r_sup, 0);
    look(mkpc(5, 1));
    chk("R6", "MRU way kept", r_hit, 1);
    look(mkpc(5, 3));
    chk("R6", "tag3 kept", r_hit, 1);
    look(mkpc(5, 4));
    chk("R6", "tag4 kept", r_hit, 1);
    look(mkpc(5, 5));
    chk("R6", "new tag resident", r_hit, 1);
    look(mkpc(5, 2));
    chk("R6", "LRU way evicted", r_hit, 0);
  endtask

  task automatic t_commit_miss;
    commit(mkpc(9, 7), 1'b1, 1'b1);
    chk("R9", "unknown commit hit", r_chit, 0);
    chk("R9", "unknown commit suppress", r_sup, 0);
    look(mkpc(9, 7));
    chk("R9", "commit did not allocate", r_hit, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_flags_bias();
    t_lru();
    t_commit_miss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule